// File: doc/BRIEF.md
# Two-buffer serial DMA engine

This block moves bytes between memory and a serial port in both directions. Each direction has two buffers, A and B. Software arms a buffer by writing a one to its load bit in a single control register. While one buffer is being transferred, software can refill and re-arm the other, so the stream continues without a gap. The start and end addresses of every buffer come in on dedicated address inputs. The engine copies them into its own registers when the buffer is armed, so software may change those inputs later without effect.

On the transmit side the engine reads one byte at a time from memory over a request/acknowledge port. It offers each byte to the serial transmitter over a valid/ready handshake. On the receive side it accepts bytes from the serial receiver over a valid/ready handshake and writes them one at a time to memory over a second request/acknowledge port. Each direction has a write-one reset bit. It aborts that direction at once and clears itself.

Top module: `sdma_top`

## Requirements
- R1: After reset `reg_rdata` reads 0. The register bits are:
  - bit 0: RX buffer A status
  - bit 1: RX buffer B status
  - bit 2: TX buffer A status
  - bit 3: TX buffer B status

  Bits 31:4, including the two reset positions, always read 0.
- R2: Arming a buffer:
  - Writing `reg_wdata` with a 1 in a load bit arms that buffer. The same write copies its start and end address inputs.
  - The buffer's status bit reads 1 from the cycle after the write.
  - A 0 in a load bit has no effect.
  - A 1 written to a buffer that is already armed has no effect. Its addresses are not copied again.
- R3: A buffer covers every address from start to end inclusive, in ascending order, with one byte per memory access.
  - On transmit, the address advances only when the serial side accepts the byte.
  - On receive, the address advances only on a memory write acknowledge.
- R4: When A and B of one direction are armed in the same write, all of A is transferred before any of B.
- R5: Buffer selection:
  - When a buffer finishes and the other buffer of that direction is armed, the other buffer starts with no idle cycle.
  - An idle channel serves whichever single buffer gets armed, B included.
  - A buffer armed while its partner is active follows that partner.
- R6: A buffer's status bit returns to 0 in the cycle after its last byte completes. On transmit, completion is the serial acceptance of the last byte. On receive, completion is the memory acknowledge of the last byte. With nothing pending, the channel then idles.
- R7: Direction reset:
  - `reg_wdata` bit 4 resets the receive direction and bit 5 resets the transmit direction.
  - A reset clears both status bits of its direction and masks that direction's memory request and serial handshake in the write cycle.
  - The reset discards any byte held and leaves the channel idle from the next cycle.
  - The other direction is unaffected.
  - A reset wins over a load bit of the same direction in the same write.
- R8: A memory request keeps its address and data stable until acknowledged. `tx_valid` keeps `tx_data` stable until `tx_ready`. The only exception is a reset of that direction.
- R9: `rx_ready` is high only while the receive channel has an active buffer and holds no byte. An idle receive channel accepts no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 6 | Control write data: load and reset bits |
| reg_rdata | output | 32 | Control register read value |
| tx_start_a | input | AW | TX buffer A first address |
| tx_end_a | input | AW | TX buffer A last address |
| tx_start_b | input | AW | TX buffer B first address |
| tx_end_b | input | AW | TX buffer B last address |
| rx_start_a | input | AW | RX buffer A first address |
| rx_end_a | input | AW | RX buffer A last address |
| rx_start_b | input | AW | RX buffer B first address |
| rx_end_b | input | AW | RX buffer B last address |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rd_data | input | DW | Memory read data |
| tx_valid | output | 1 | Byte offered to serial transmitter |
| tx_data | output | DW | Transmit byte |
| tx_ready | input | 1 | Serial transmitter accepts |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| mem_wr_ack | input | 1 | Memory write acknowledge |
| rx_valid | input | 1 | Serial receiver has a byte |
| rx_data | input | DW | Received byte |
| rx_ready | output | 1 | Engine accepts the received byte |

## Verification
The sharpest collision is a direction reset landing in the same cycle as an in-flight memory acknowledge or a serial handshake of that direction. The bench provokes it by writing the reset bit while a long buffer streams under irregular ready and acknowledge patterns. It then judges that:
- the status bits read zero;
- the request and valid are already low;
- no further byte appears;
- the other direction's status stays set.

A second collision is a load write hitting while a buffer of the same direction is being processed. This covers both re-arming the active buffer and arming the partner. The bench judges it by the exact byte sequence and address order received, compared with a list built from the requirements.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int CTL_W    = 32;
  localparam int CTL_WR_W = 6;
  localparam int BIT_RX_LA  = 0;
  localparam int BIT_RX_LB  = 1;
  localparam int BIT_TX_LA  = 2;
  localparam int BIT_TX_LB  = 3;
  localparam int BIT_RX_RST = 4;
  localparam int BIT_TX_RST = 5;

  typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_sel_e;

  // A beats B when both are waiting.
  function automatic buf_sel_e first_armed(input logic [1:0] arm);
    return arm[0] ? BUF_A : BUF_B;
  endfunction

  // Readable control word: only status bits, everything else zero.
  function automatic logic [CTL_W-1:0] ctl_status(input logic [1:0] rx_arm,
                                                 input logic [1:0] tx_arm);
    logic [CTL_W-1:0] w;
    w = '0;
    w[BIT_RX_LB:BIT_RX_LA] = rx_arm;
    w[BIT_TX_LB:BIT_TX_LA] = tx_arm;
    return w;
  endfunction
endpackage

// File: rtl/sdma_bufsel.sv
module sdma_bufsel
  import sdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [1:0]          load,
  input  logic [1:0][AW-1:0]  start_in,
  input  logic [1:0][AW-1:0]  end_in,
  input  logic                step,
  output logic [1:0]          armed,
  output logic                active,
  output logic [AW-1:0]       addr,
  output logic                finish
);
  buf_sel_e          cur;
  buf_sel_e          other;
  buf_sel_e          pick;
  logic [1:0][AW-1:0] st_q;
  logic [1:0][AW-1:0] en_q;
  logic              last;

  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  assign other  = buf_sel_e'(~cur);
  assign pick   = first_armed(armed);
  assign last   = (addr == en_q[cur]);
  assign finish = active && step && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= '0;
      active <= 1'b0;
      cur    <= BUF_A;
      addr   <= '0;
      st_q   <= '0;
      en_q   <= '0;
    end else if (flush) begin
      armed  <= '0;
      active <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (load[b] && !armed[b]) begin
          armed[b] <= 1'b1;
          st_q[b]  <= start_in[b];
          en_q[b]  <= end_in[b];
        end
      end
      if (active) begin
        if (step) begin
          if (last) begin
            armed[cur] <= 1'b0;
            if (armed[other]) begin
              cur  <= other;
              addr <= st_q[other];
            end else begin
              active <= 1'b0;
            end
          end else begin
            addr <= addr_inc(addr);
          end
        end
      end else if (|armed) begin
        active <= 1'b1;
        cur    <= pick;
        addr   <= st_q[pick];
      end
    end
  end
endmodule

// File: rtl/sdma_tx_path.sv
module sdma_tx_path #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          active,
  input  logic [AW-1:0] addr,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [DW-1:0] mem_rd_data,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          step
);
  logic          hold_v;
  logic [DW-1:0] hold_d;
  logic          fetch_done;

  assign mem_rd_req  = active && !hold_v && !flush;
  assign mem_rd_addr = addr;
  assign fetch_done  = mem_rd_req && mem_rd_ack;
  assign tx_valid    = hold_v && !flush;
  assign tx_data     = hold_d;
  assign step        = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (flush) begin
      hold_v <= 1'b0;
    end else if (fetch_done) begin
      hold_v <= 1'b1;
      hold_d <= mem_rd_data;
    end else if (step) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/sdma_rx_path.sv
module sdma_rx_path #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          active,
  input  logic [AW-1:0] addr,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_ack,
  output logic          step
);
  logic          hold_v;
  logic [DW-1:0] hold_d;
  logic          take;

  assign rx_ready    = active && !hold_v && !flush;
  assign take        = rx_valid && rx_ready;
  assign mem_wr_req  = hold_v && !flush;
  assign mem_wr_addr = addr;
  assign mem_wr_data = hold_d;
  assign step        = mem_wr_req && mem_wr_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (flush) begin
      hold_v <= 1'b0;
    end else if (take) begin
      hold_v <= 1'b1;
      hold_d <= rx_data;
    end else if (step) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/sdma_top.sv
module sdma_top
  import sdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [CTL_WR_W-1:0] reg_wdata,
  output logic [CTL_W-1:0]    reg_rdata,
  input  logic [AW-1:0]       tx_start_a,
  input  logic [AW-1:0]       tx_end_a,
  input  logic [AW-1:0]       tx_start_b,
  input  logic [AW-1:0]       tx_end_b,
  input  logic [AW-1:0]       rx_start_a,
  input  logic [AW-1:0]       rx_end_a,
  input  logic [AW-1:0]       rx_start_b,
  input  logic [AW-1:0]       rx_end_b,
  output logic                mem_rd_req,
  output logic [AW-1:0]       mem_rd_addr,
  input  logic                mem_rd_ack,
  input  logic [DW-1:0]       mem_rd_data,
  output logic                tx_valid,
  output logic [DW-1:0]       tx_data,
  input  logic                tx_ready,
  output logic                mem_wr_req,
  output logic [AW-1:0]       mem_wr_addr,
  output logic [DW-1:0]       mem_wr_data,
  input  logic                mem_wr_ack,
  input  logic                rx_valid,
  input  logic [DW-1:0]       rx_data,
  output logic                rx_ready
);
  // Named internal events, also observed by the bound checker.
  logic          tx_flush, rx_flush;
  logic [1:0]    tx_load, rx_load;
  logic [1:0]    tx_armed, rx_armed;
  logic          tx_active, rx_active;
  logic [AW-1:0] tx_addr, rx_addr;
  logic          tx_step, rx_step;
  logic          tx_finish, rx_finish;

  assign tx_flush  = reg_we && reg_wdata[BIT_TX_RST];
  assign rx_flush  = reg_we && reg_wdata[BIT_RX_RST];
  assign tx_load   = reg_we ? reg_wdata[BIT_TX_LB:BIT_TX_LA] : 2'b00;
  assign rx_load   = reg_we ? reg_wdata[BIT_RX_LB:BIT_RX_LA] : 2'b00;
  assign reg_rdata = ctl_status(rx_armed, tx_armed);

  sdma_bufsel #(.AW(AW)) u_tx_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (tx_flush),
    .load     (tx_load),
    .start_in ({tx_start_b, tx_start_a}),
    .end_in   ({tx_end_b, tx_end_a}),
    .step     (tx_step),
    .armed    (tx_armed),
    .active   (tx_active),
    .addr     (tx_addr),
    .finish   (tx_finish)
  );

  sdma_bufsel #(.AW(AW)) u_rx_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (rx_flush),
    .load     (rx_load),
    .start_in ({rx_start_b, rx_start_a}),
    .end_in   ({rx_end_b, rx_end_a}),
    .step     (rx_step),
    .armed    (rx_armed),
    .active   (rx_active),
    .addr     (rx_addr),
    .finish   (rx_finish)
  );

  sdma_tx_path #(.AW(AW), .DW(DW)) u_tx_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (tx_flush),
    .active      (tx_active),
    .addr        (tx_addr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready),
    .step        (tx_step)
  );

  sdma_rx_path #(.AW(AW), .DW(DW)) u_rx_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (rx_flush),
    .active      (rx_active),
    .addr        (rx_addr),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_ack  (mem_wr_ack),
    .step        (rx_step)
  );
endmodule

// File: rtl/sdma_top_chk.sv
module sdma_top_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [5:0]    reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          mem_rd_req,
  input logic          mem_rd_ack,
  input logic [AW-1:0] mem_rd_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          mem_wr_req,
  input logic          mem_wr_ack,
  input logic [AW-1:0] mem_wr_addr,
  input logic [DW-1:0] mem_wr_data,
  input logic          rx_ready,
  input logic          tx_step,
  input logic          rx_step,
  input logic          tx_finish,
  input logic          rx_finish
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:4] == '0);

  p_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata[3:0] & ~$past(reg_rdata[3:0])) != 4'b0) |->
      ($past(reg_we) &&
       (((reg_rdata[3:0] & ~$past(reg_rdata[3:0])) & ~$past(reg_wdata[3:0])) == 4'b0)));

  p_tx_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_step && !tx_finish) |=> (mem_rd_addr == $past(mem_rd_addr) + AW'(1)));

  p_rx_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_step && !rx_finish) |=> (mem_wr_addr == $past(mem_wr_addr) + AW'(1)));

  p_tx_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_finish |=> (reg_rdata[3:2] != 2'b11));

  p_rx_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_finish |=> (reg_rdata[1:0] != 2'b11));

  p_tx_reset_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[5]) |=> (reg_rdata[3:2] == 2'b00 && !tx_valid && !mem_rd_req));

  p_rx_reset_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[4]) |=> (reg_rdata[1:0] == 2'b00 && !rx_ready && !mem_wr_req));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=>
      ($stable(mem_rd_addr) && (mem_rd_req || (reg_we && reg_wdata[5]))));

  p_txv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=>
      ($stable(tx_data) && (tx_valid || (reg_we && reg_wdata[5]))));

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=>
      ($stable(mem_wr_addr) && $stable(mem_wr_data) &&
       (mem_wr_req || (reg_we && reg_wdata[4]))));

  p_rx_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (reg_rdata[1:0] != 2'b00));
endmodule

bind sdma_top sdma_top_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_ack  (mem_rd_ack),
  .mem_rd_addr (mem_rd_addr),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_ack  (mem_wr_ack),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .rx_ready    (rx_ready),
  .tx_step     (tx_step),
  .rx_step     (rx_step),
  .tx_finish   (tx_finish),
  .rx_finish   (rx_finish)
);

// File: tb/sdma_top_tb_top.sv
`timescale 1ns/1ps
module sdma_top_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reg_we;
  logic [5:0]    reg_wdata;
  logic [31:0]   reg_rdata;
  logic [AW-1:0] tx_start_a, tx_end_a, tx_start_b, tx_end_b;
  logic [AW-1:0] rx_start_a, rx_end_a, rx_start_b, rx_end_b;
  logic          mem_rd_req, mem_rd_ack;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic          tx_valid, tx_ready;
  logic [DW-1:0] tx_data;
  logic          mem_wr_req, mem_wr_ack;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          rx_valid, rx_ready;
  logic [DW-1:0] rx_data;

  sdma_top #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_start_a(tx_start_a), .tx_end_a(tx_end_a), .tx_start_b(tx_start_b), .tx_end_b(tx_end_b),
    .rx_start_a(rx_start_a), .rx_end_a(rx_end_a), .rx_start_b(rx_start_b), .rx_end_b(rx_end_b),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Memory content model: byte depends on both address halves.
  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  logic [7:0]    tx_log [0:255];
  int            tx_n = 0;
  logic [AW-1:0] wr_log_a [0:255];
  logic [7:0]    wr_log_d [0:255];
  int            wr_n = 0;
  int            rx_seq = 0;
  logic          rx_src_en = 1'b0;

  logic [AW-1:0] exp_a [0:255];
  int            exp_n = 0;

  // Responders: drive just after the falling edge, log handshakes that will complete.
  initial begin
    tx_ready = 0; mem_rd_ack = 0; mem_rd_data = 0; mem_wr_ack = 0; rx_valid = 0; rx_data = 0;
    forever begin
      @(negedge clk); #1;
      mem_rd_ack  = mem_rd_req && cyc[0];
      mem_rd_data = mem_byte(mem_rd_addr);
      mem_wr_ack  = mem_wr_req && (cyc % 3 != 0);
      tx_ready    = (cyc % 3 != 1);
      rx_valid    = rx_src_en && (cyc % 4 != 2);
      rx_data     = 8'h30 + rx_seq[7:0];
      #1;
      if (tx_valid && tx_ready && tx_n < 256) begin
        tx_log[tx_n] = tx_data; tx_n++;
      end
      if (mem_wr_req && mem_wr_ack && wr_n < 256) begin
        wr_log_a[wr_n] = mem_wr_addr; wr_log_d[wr_n] = mem_wr_data; wr_n++;
      end
      if (rx_valid && rx_ready) rx_seq++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic wr(input logic [5:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    #3;
  endtask

  task automatic wait_idle(input logic [31:0] mask, input string tag);
    int k;
    k = 0;
    while ((reg_rdata & mask) != 0 && k < 3000) begin
      tick(1); k++;
    end
    chk(tag, reg_rdata & mask, 32'h0);
  endtask

  task automatic add_range(input logic [AW-1:0] sa, input int len);
    for (int i = 0; i < len; i++) begin
      exp_a[exp_n] = sa + AW'(i); exp_n++;
    end
  endtask

  // Vector: {dir(1:rx), load bits {B,A}, startA, lenA, startB, lenB}
  localparam int NV = 7;
  localparam logic [50:0] VEC [0:NV-1] = '{
    {1'b0, 2'b01, 16'h0100, 8'd4, 16'h0000, 8'd1},
    {1'b0, 2'b10, 16'h0000, 8'd1, 16'h0200, 8'd3},
    {1'b0, 2'b11, 16'h0300, 8'd2, 16'h0310, 8'd3},
    {1'b0, 2'b11, 16'h0455, 8'd1, 16'h0566, 8'd1},
    {1'b1, 2'b01, 16'h1000, 8'd5, 16'h0000, 8'd1},
    {1'b1, 2'b11, 16'h2000, 8'd3, 16'h2100, 8'd2},
    {1'b1, 2'b10, 16'h0000, 8'd1, 16'h3000, 8'd4}
  };

  task automatic run_vec(input logic [50:0] v);
    logic          dir;
    logic [1:0]    ld;
    logic [AW-1:0] sa, sb;
    int            la, lb, base, got;
    dir = v[50]; ld = v[49:48]; sa = v[47:32]; la = int'(v[31:24]);
    sb = v[23:8]; lb = int'(v[7:0]);
    if (dir) begin
      rx_start_a = sa; rx_end_a = sa + AW'(la - 1);
      rx_start_b = sb; rx_end_b = sb + AW'(lb - 1);
    end else begin
      tx_start_a = sa; tx_end_a = sa + AW'(la - 1);
      tx_start_b = sb; tx_end_b = sb + AW'(lb - 1);
    end
    tx_n = 0; wr_n = 0; exp_n = 0; base = rx_seq;
    if (ld[0]) add_range(sa, la);
    if (ld[1]) add_range(sb, lb);
    rx_src_en = dir;
    wr(dir ? {4'b0, ld} : {2'b0, ld, 2'b0});
    chk("R2 status after load", dir ? {30'b0, reg_rdata[1:0]} : {30'b0, reg_rdata[3:2]}, {30'b0, ld});
    wait_idle(dir ? 32'h3 : 32'hC, "R6 status clears at completion");
    rx_src_en = 1'b0;
    got = dir ? wr_n : tx_n;
    chk("R3 byte count", got, exp_n);
    for (int i = 0; i < exp_n && i < got; i++) begin
      if (dir) begin
        chk("R4 R5 rx address order", {16'b0, wr_log_a[i]}, {16'b0, exp_a[i]});
        chk("R3 rx data", {24'b0, wr_log_d[i]}, {24'b0, 8'h30 + 8'(base + i)});
      end else begin
        chk("R4 R5 tx byte order", {24'b0, tx_log[i]}, {24'b0, mem_byte(exp_a[i])});
      end
    end
  endtask

  task automatic wait_count(input int which, input int n);
    int k;
    k = 0;
    while (((which == 0) ? tx_n : wr_n) < n && k < 2000) begin
      tick(1); k++;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog R6 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    reg_we = 0; reg_wdata = 0;
    tx_start_a = 0; tx_end_a = 0; tx_start_b = 0; tx_end_b = 0;
    rx_start_a = 0; rx_end_a = 0; rx_start_b = 0; rx_end_b = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset value", reg_rdata, 32'h0);
    chk("R9 rx_ready idle", {31'b0, rx_ready}, 32'h0);
    chk("R1 no read request at reset", {31'b0, mem_rd_req}, 32'h0);

    wr(6'h00);
    chk("R2 zero write no effect", reg_rdata, 32'h0);
    wr(6'h30);
    chk("R1 reset bits read zero", reg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2 R5: re-arm active A (ignored) together with B while A runs.
    tx_n = 0; exp_n = 0;
    tx_start_a = 16'h0600; tx_end_a = 16'h0609;
    wr(6'h04);
    wait_count(0, 2);
    tx_start_a = 16'h0700; tx_end_a = 16'h0709;
    tx_start_b = 16'h0800; tx_end_b = 16'h0802;
    wr(6'h0C);
    chk("R5 A active B pending", {30'b0, reg_rdata[3:2]}, 32'h3);
    wait_idle(32'hC, "R6 chain completes");
    add_range(16'h0600, 10);
    add_range(16'h0800, 3);
    chk("R2 R5 chained count", tx_n, exp_n);
    for (int i = 0; i < exp_n && i < tx_n; i++)
      chk("R2 R5 chained order", {24'b0, tx_log[i]}, {24'b0, mem_byte(exp_a[i])});

    // R7: tx reset mid-transfer while rx stays armed.
    rx_start_a = 16'h0900; rx_end_a = 16'h0931;
    wr(6'h01);
    tx_n = 0;
    tx_start_a = 16'h0A00; tx_end_a = 16'h0A27;
    wr(6'h04);
    wait_count(0, 3);
    wr(6'h20);
    chk("R7 tx status cleared", {30'b0, reg_rdata[3:2]}, 32'h0);
    chk("R7 rx direction untouched", {30'b0, reg_rdata[1:0]}, 32'h1);
    chk("R7 tx_valid dropped", {31'b0, tx_valid}, 32'h0);
    chk("R7 read request dropped", {31'b0, mem_rd_req}, 32'h0);
    n0 = tx_n;
    tick(30);
    chk("R7 no bytes after reset", tx_n, n0);
    for (int i = 0; i < n0; i++)
      chk("R7 prefix before reset", {24'b0, tx_log[i]}, {24'b0, mem_byte(16'h0A00 + AW'(i))});
    wr(6'h10);
    chk("R7 rx reset clears", reg_rdata, 32'h0);
    chk("R9 rx_ready after reset", {31'b0, rx_ready}, 32'h0);

    // R7: reset wins over load in the same write.
    wr(6'h24);
    chk("R7 reset beats load", reg_rdata, 32'h0);
    tick(5);
    chk("R7 stays idle", {31'b0, mem_rd_req}, 32'h0);

    // R7: rx reset mid-transfer.
    wr_n = 0;
    rx_start_a = 16'h0B00; rx_end_a = 16'h0B13;
    rx_src_en = 1'b1;
    wr(6'h01);
    wait_count(1, 3);
    wr(6'h10);
    chk("R7 rx status cleared mid", reg_rdata, 32'h0);
    chk("R7 write request dropped", {31'b0, mem_wr_req}, 32'h0);
    chk("R9 rx_ready dropped", {31'b0, rx_ready}, 32'h0);
    n0 = wr_n;
    tick(20);
    chk("R9 idle rx writes nothing", wr_n, n0);
    rx_src_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule